// File: doc/BRIEF.md
# Page Table Walker for TLB Refill

This block refills a translation buffer after a miss. It looks the missing page up in a page table that has one level and sits in main memory. The caller hands over a 20-bit virtual page number, a flag that marks the access as a store, and the byte address of the table base. The walker forms the entry address and reads the 32-bit entry through a request/response memory port. It then ends the walk in one of two ways: it returns the 18-bit physical page number for loading into the TLB, or it reports a page fault when the entry marks the page as not resident. The page offset (bits 11..0) is not involved: the TLB joins it to the returned physical page number to form the 30-bit physical address.

The entry uses this layout: bit 31 is present, bit 30 is modified, bit 29 is accessed, and bits 17..0 hold the physical page number. A successful walk sets the accessed bit. A store also sets the modified bit. The updated entry goes back to memory only when one of these bits actually changes. A faulting walk leaves the entry untouched. Only one walk runs at a time.

Top module: `pt_walker`

## Requirements
- R1: The entry is read from byte address `base + 4*vpn`, computed modulo 2^32. Exactly one read is issued per walk.
- R2: When bit 31 of the entry is set, the walk ends with a one-cycle completion in which `done_fault` is 0, `done_ppn` equals entry bits 17..0 and `done_vpn` echoes the requested page number.
- R3: When bit 31 of the entry is clear, the walk ends with `done_fault` at 1 and `done_ppn` at 0, whatever the other bits of the entry hold.
- R4: A faulting walk issues no memory write, and the entry in memory keeps its old value.
- R5: Every entry that a successful walk writes back has the accessed bit (bit 29) set.
- R6: A store walk writes back an entry with the modified bit (bit 30) set. A load walk keeps the modified bit as it was read.
- R7: A successful walk issues exactly one write when the accessed bit, or for a store the modified bit, was clear. It issues no write when those bits were already set.
- R8: The write-back goes to the address that was read and keeps every other bit of the entry, the page number and bits 28..18 included.
- R9: `miss_ready` is high only while the walker is idle. It is low from the cycle after a miss is accepted until the walk completes.
- R10: `done_valid` is high for one cycle per walk.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request keeps the same address, direction and write data in the next cycle.
- R12: After reset, `miss_ready` is 1 and both `mem_req_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | A TLB miss is offered |
| miss_ready | output | 1 | The walker can take a miss (it is idle) |
| miss_vpn | input | 20 | Virtual page number that missed |
| miss_store | input | 1 | The missing access is a store |
| pt_base | input | 32 | Byte address of the page table |
| mem_req_valid | output | 1 | A memory request is presented |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for the entry write-back, 0 for the entry read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for the write-back |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | 32 | Entry that was read |
| done_valid | output | 1 | One-cycle completion of a walk |
| done_fault | output | 1 | The page is not resident |
| done_vpn | output | 20 | Page number of the completed walk |
| done_ppn | output | 18 | Physical page number (0 on a fault) |

## Verification
The hardest case to reach is a write-back that memory stalls: the updated entry has to stay on the port, unchanged, while ready is low. This can only happen on a walk that actually changes a status bit. The memory model therefore drops ready in a pseudo-random pattern and returns read data after a varying delay. The walk sequence is arranged so that several walks need a write-back and so meet that pattern. A separate case puts the table base near the top of the address space, so that the entry address wraps around.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 30,
  parameter int PG_W   = 12,
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  parameter int V_BIT  = 31,
  parameter int D_BIT  = 30,
  parameter int R_BIT  = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [VA_W-PG_W-1:0] miss_vpn,
  input  logic              miss_store,
  input  logic [ADDR_W-1:0] pt_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [PTE_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done_valid,
  output logic              done_fault,
  output logic [VA_W-PG_W-1:0] done_vpn,
  output logic [PA_W-PG_W-1:0] done_ppn
);
  localparam int VPN_W = VA_W - PG_W;
  localparam int PPN_W = PA_W - PG_W;

  typedef enum logic [2:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_UPDATE, S_DONE, S_FAULT} state_t;

  state_t             state;
  logic [VPN_W-1:0]   vpn_q;
  logic               store_q;
  logic [ADDR_W-1:0]  base_q;
  logic [PTE_W-1:0]   pte_q;

  wire [PTE_W-1:0] new_pte = pte_q | (PTE_W'(1) << R_BIT) | (PTE_W'(store_q) << D_BIT);
  wire             present = pte_q[V_BIT];
  wire             need_wb = new_pte != pte_q;

  assign miss_ready    = state == S_IDLE;
  assign mem_req_valid = (state == S_RD_REQ) || (state == S_UPDATE && present && need_wb);
  assign mem_req_write = state == S_UPDATE;
  assign mem_req_addr  = base_q + ADDR_W'({vpn_q, 2'b00});
  assign mem_req_wdata = new_pte;
  assign done_valid    = (state == S_DONE) || (state == S_FAULT);
  assign done_fault    = state == S_FAULT;
  assign done_vpn      = vpn_q;
  assign done_ppn      = (state == S_FAULT) ? '0 : pte_q[PPN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      vpn_q   <= '0;
      store_q <= 1'b0;
      base_q  <= '0;
      pte_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (miss_valid) begin
          vpn_q   <= miss_vpn;
          store_q <= miss_store;
          base_q  <= pt_base;
          state   <= S_RD_REQ;
        end
        S_RD_REQ:  if (mem_req_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          pte_q <= mem_rsp_data;
          state <= S_UPDATE;
        end
        S_UPDATE: begin
          if (!present)                     state <= S_FAULT;
          else if (!need_wb || mem_req_ready) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)); // R11
  AST_WB_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[V_BIT]); // R4
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[R_BIT]); // R5
  AST_FAULT_NO_PPN: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> done_ppn == '0); // R3
  AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> !miss_ready); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R10
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 0, rst_n = 0;
  logic        miss_valid = 0, miss_store = 0;
  logic [19:0] miss_vpn = '0;
  logic [31:0] pt_base = '0;
  logic        miss_ready, mem_req_valid, mem_req_write, done_valid, done_fault;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;
  logic [19:0] done_vpn;
  logic [17:0] done_ppn;

  always #2.5 clk = ~clk;

  pt_walker uut (.clk, .rst_n, .miss_valid, .miss_ready, .miss_vpn, .miss_store, .pt_base,
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_data, .done_valid, .done_fault, .done_vpn, .done_ppn);

  int tests = 0, fails = 0, done_cnt = 0;
  logic [31:0] mem [256];
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [7:0]  lfsr = 8'hA5;
  logic        pend = 0, stalled = 0, hold_err = 0;
  logic [1:0]  lat = 0;
  logic [7:0]  rd_idx = 0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic        st_write = 0;
  logic [38:0] expq [$];

  // memory model: pseudo-random ready, variable read latency
  always @(posedge clk) begin
    if (stalled && (!mem_req_valid || mem_req_addr != st_addr || mem_req_write != st_write
                    || mem_req_wdata != st_data)) hold_err = 1;
    stalled = mem_req_valid && !mem_req_ready;
    st_addr = mem_req_addr; st_write = mem_req_write; st_data = mem_req_wdata;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[rd_idx];
        pend = 0;
      end else lat = lat - 1;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[9:2]] = mem_req_wdata;
        wr_cnt++; last_wr_addr = mem_req_addr;
      end else begin
        pend = 1; lat = lfsr[1:0]; rd_idx = mem_req_addr[9:2];
        rd_cnt++; last_rd_addr = mem_req_addr;
      end
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= lfsr[0] | lfsr[2];
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && done_valid) begin
      logic [38:0] e;
      e = expq.pop_front();
      tests++;
      if ({done_fault, done_ppn, done_vpn} != e) begin
        fails++;
        $display("FAIL R2/R3 completion: got fault=%0d ppn=%h vpn=%h, expected fault=%0d ppn=%h vpn=%h",
          done_fault, done_ppn, done_vpn, e[38], e[37:20], e[19:0]);
      end
      done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] base, input logic [19:0] vpn, input bit st,
                      input bit exp_fault, input int exp_wr, input logic [31:0] exp_pte);
    int w0, r0, target;
    logic [31:0] ea, pte0;
    ea = base + {10'd0, vpn, 2'b00};
    pte0 = mem[ea[9:2]];
    expq.push_back({exp_fault, exp_fault ? 18'd0 : pte0[17:0], vpn});
    w0 = wr_cnt; r0 = rd_cnt; target = done_cnt + 1;
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    miss_valid = 1; miss_vpn = vpn; miss_store = st; pt_base = base;
    @(negedge clk);
    miss_valid = 0;
    chk(miss_ready == 0, "R9 busy after accept", {31'd0, miss_ready}, 0);
    while (done_cnt < target) @(negedge clk);
    chk(rd_cnt - r0 == 1 && last_rd_addr == ea, "R1 read address", last_rd_addr, ea);
    chk(wr_cnt - w0 == exp_wr, "R7 write count", wr_cnt - w0, exp_wr);
    chk(mem[ea[9:2]] == exp_pte, exp_fault ? "R4 entry unchanged" : "R5/R6/R8 entry after walk",
        mem[ea[9:2]], exp_pte);
    if (exp_wr > 0) chk(last_wr_addr == ea, "R8 write address", last_wr_addr, ea);
    @(negedge clk);
    chk(done_valid == 0, "R10 single pulse", {31'd0, done_valid}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[8'h43] = 32'h8000_1234;
    mem[8'h45] = 32'h0000_2222;
    mem[8'h46] = 32'h4000_3333;
    mem[8'h47] = 32'hC003_FFFF;
    mem[8'h48] = 32'h9FFC_0001;
    mem[8'h49] = 32'hA000_0000;
    mem[8'hFF] = 32'h8000_0ABC;
    repeat (3) @(negedge clk);
    chk(miss_ready == 1 && mem_req_valid == 0 && done_valid == 0, "R12 reset state",
        {29'd0, miss_ready, mem_req_valid, done_valid}, 32'h4);
    rst_n = 1;
    walk(32'h100, 20'd3, 0, 0, 1, 32'hA000_1234);  // R5 load sets accessed
    walk(32'h100, 20'd3, 0, 0, 0, 32'hA000_1234);  // R7 no change, no write
    walk(32'h100, 20'd3, 1, 0, 1, 32'hE000_1234);  // R6 store sets modified
    walk(32'h100, 20'd3, 1, 0, 0, 32'hE000_1234);  // R7 already set
    walk(32'h100, 20'd5, 1, 1, 0, 32'h0000_2222);  // R3 R4 fault on store
    walk(32'h100, 20'd6, 0, 1, 0, 32'h4000_3333);  // R3 R4 fault, other bits set
    walk(32'h100, 20'd7, 0, 0, 1, 32'hE003_FFFF);  // R6 load keeps modified
    walk(32'h100, 20'd8, 1, 0, 1, 32'hFFFC_0001);  // R8 other bits kept
    walk(32'h100, 20'd9, 0, 0, 0, 32'hA000_0000);  // R2 ppn 0 not a fault
    walk(32'hFFC0_0400, 20'hFFFFF, 0, 0, 1, 32'hA000_0ABC); // R1 address wraps
    chk(hold_err == 0, "R11 stalled request held", {31'd0, hold_err}, 0);
    chk(expq.size() == 0, "R10 completions match walks", expq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule